// File: doc/BRIEF.md
# CAN Controller Bring-Up and Transmit Sequencer

This block drives a byte-wide SPI master port to start an external CAN controller that sits on an SPI bus, and then sends frames through it. After reset it runs a fixed script with no outside help. First it resets the controller. Then it waits a programmable interval and reads one status byte. Last, it writes the bit-timing, interrupt-enable and receive-filter registers, with the controller held in configuration mode. When the script ends, it returns the controller to normal operation and raises `tx_ready`.

A transmit request carries a packed 32-bit identifier word, a 4-bit length and up to eight data bytes. The identifier word holds the standard ID bits 10:3 in bits 31:24 and ID bits 2:0 in bits 23:21. Bit 19 is the extended-ID flag, and bits 17:16 and 15:0 carry extended ID bits 17:0. The sequencer sends the request as two chip-select frames. The first loads transmit buffer 0. The second is a single request-to-send command for that buffer. Each byte is handed to an external shifter through a request/acknowledge pair. The shifter returns the byte it clocked in at the same time.

Top module: `can_spi_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `spi_cs_n` is 1, `spi_req` is 0 and `tx_ready` is 0.
- R2: The first frame holds only the byte 0xC0. The next frame starts no sooner than `RESET_WAIT_CYCLES` cycles after `spi_cs_n` rises at the end of that frame.
- R3: The second frame is 0xB0 then 0xFF. `status_byte` holds the `spi_rx` value returned with the 0xFF byte.
- R4: The next four frames, in this order, are: 02 2F 80; 02 28 01 81 P A7; 02 70 60; 02 2F 00. P is 0x0B, or 0x05 when `XTAL_8MHZ` is 1.
- R5: Between any two frames `spi_cs_n` stays high for at least `CS_GAP_CYCLES` cycles. `spi_req` is high only while `spi_cs_n` is low.
- R6: Once raised, `spi_req` stays high with `spi_byte` unchanged until `spi_ack` is seen. It is low on the cycle after the acknowledge, so each acknowledge moves exactly one byte.
- R7: `tx_ready` is high only while idle after the script has finished. A request is taken on a cycle with `tx_valid` and `tx_ready` both high, and `tx_ready` is low on the next cycle.
- R8: A taken request produces one frame: 0x40, `tx_id[31:24]`, `tx_id[23:16]`, `tx_id[15:8]`, `tx_id[7:0]`, the length byte, then that many data bytes, starting with `tx_data[7:0]`.
- R9: A `tx_len` above `MAX_DATA` is sent as `MAX_DATA` in the length byte, followed by `MAX_DATA` data bytes.
- R10: Every load frame is followed by a separate frame holding only 0x81.
- R11: A `tx_valid` held high during the start-up script, or during another transmit, starts no frame until the sequencer is idle. The frame stream then matches the scripts exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Transmit request present |
| tx_ready | output | 1 | Sequencer idle and able to take a request |
| tx_id | input | 32 | Packed identifier word |
| tx_len | input | 4 | Requested data length |
| tx_data | input | 8*MAX_DATA | Data bytes, byte 0 in bits 7:0 |
| spi_cs_n | output | 1 | Chip select to the controller, active low |
| spi_req | output | 1 | Request to shift `spi_byte` |
| spi_byte | output | 8 | Byte to send |
| spi_ack | input | 1 | One-cycle pulse when the shifter has finished a byte |
| spi_rx | input | 8 | Byte received during the acknowledged transfer |
| status_byte | output | 8 | Status byte captured during start-up |

## Verification
The assertions assume that the shifter raises `spi_ack` only while `spi_req` is high, as a single-cycle pulse. They also assume that `spi_rx` is valid in the same cycle as that pulse. The bench's shifter model acknowledges each request three cycles after it sees it and drops the acknowledge straight away. It never acknowledges when no request is pending. Requests are driven on falling edges and are held until they are taken, as the handshake expects. The bench sweeps every length code from 0 to 15, so the clamp sees every value above the limit.

// File: rtl/can_seq_pkg.sv
package can_seq_pkg;

  typedef enum logic [1:0] {ST_GAP, ST_SEND, ST_RSTWAIT, ST_IDLE} seq_state_t;
  typedef enum logic [1:0] {PH_INIT, PH_LOAD, PH_RTS, PH_DONE} seq_phase_t;

  localparam int INIT_LEN = 18;
  localparam logic [7:0] OP_LOAD_TXB0 = 8'h40;
  localparam logic [7:0] OP_RTS_TXB0  = 8'h81;

  // Start-up script entry: {last byte of frame, byte}
  function automatic logic [8:0] init_entry(input logic [4:0] idx, input logic [7:0] presc);
    logic [8:0] e;
    case (idx)
      5'd0:  e = {1'b1, 8'hC0};
      5'd1:  e = {1'b0, 8'hB0};
      5'd2:  e = {1'b1, 8'hFF};
      5'd3:  e = {1'b0, 8'h02};
      5'd4:  e = {1'b0, 8'h2F};
      5'd5:  e = {1'b1, 8'h80};
      5'd6:  e = {1'b0, 8'h02};
      5'd7:  e = {1'b0, 8'h28};
      5'd8:  e = {1'b0, 8'h01};
      5'd9:  e = {1'b0, 8'h81};
      5'd10: e = {1'b0, presc};
      5'd11: e = {1'b1, 8'hA7};
      5'd12: e = {1'b0, 8'h02};
      5'd13: e = {1'b0, 8'h70};
      5'd14: e = {1'b1, 8'h60};
      5'd15: e = {1'b0, 8'h02};
      5'd16: e = {1'b0, 8'h2F};
      5'd17: e = {1'b1, 8'h00};
      default: e = {1'b1, 8'h00};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/can_seq_timer.sv
module can_seq_timer #(
  parameter int W = 8,
  parameter int unsigned RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)                count_q <= W'(RST_VAL);
    else if (load)          count_q <= load_val;
    else if (count_q != '0) count_q <= count_q - 1'b1;
  end

  assign expired = (count_q == '0);
endmodule

// File: rtl/can_seq_txbuf.sv
module can_seq_txbuf #(
  parameter int MAX_DATA = 8,
  parameter int LEN_W = 4,
  parameter int SEL_W = 5
) (
  input  logic                  clk,
  input  logic                  capture,
  input  logic [31:0]           id,
  input  logic [LEN_W-1:0]      len,
  input  logic [8*MAX_DATA-1:0] data,
  input  logic [SEL_W-1:0]      sel,
  output logic [7:0]            byte_o,
  output logic                  last_o
);
  import can_seq_pkg::*;

  localparam int NB = 6 + MAX_DATA;

  wire  [8*NB-1:0] frame_nxt;
  logic [8*NB-1:0] frame_q;
  logic [7:0]      len_c;
  logic [7:0]      len_q;

  always_comb begin
    if (int'(len) > MAX_DATA) len_c = 8'(MAX_DATA);
    else                      len_c = 8'(len);
  end

  assign frame_nxt[7:0]   = OP_LOAD_TXB0;
  assign frame_nxt[15:8]  = id[31:24];
  assign frame_nxt[23:16] = id[23:16];
  assign frame_nxt[31:24] = id[15:8];
  assign frame_nxt[39:32] = id[7:0];
  assign frame_nxt[47:40] = len_c;

  for (genvar k = 0; k < MAX_DATA; k++) begin : g_data
    assign frame_nxt[8*(6+k) +: 8] = data[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (capture) begin
      frame_q <= frame_nxt;
      len_q   <= len_c;
    end
  end

  assign byte_o = frame_q[8*int'(sel) +: 8];
  assign last_o = (int'(sel) == 5 + int'(len_q));
endmodule

// File: rtl/can_spi_seq.sv
module can_spi_seq #(
  parameter int unsigned RESET_WAIT_CYCLES = 625000,
  parameter int unsigned CS_GAP_CYCLES     = 16,
  parameter int          MAX_DATA          = 8,
  parameter bit          XTAL_8MHZ         = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [31:0]           tx_id,
  input  logic [3:0]            tx_len,
  input  logic [8*MAX_DATA-1:0] tx_data,
  output logic                  spi_cs_n,
  output logic                  spi_req,
  output logic [7:0]            spi_byte,
  input  logic                  spi_ack,
  input  logic [7:0]            spi_rx,
  output logic [7:0]            status_byte
);
  import can_seq_pkg::*;

  localparam logic [7:0]  PRESC = XTAL_8MHZ ? 8'h05 : 8'h0B;
  localparam int unsigned TMAX  = (RESET_WAIT_CYCLES > CS_GAP_CYCLES) ? RESET_WAIT_CYCLES : CS_GAP_CYCLES;
  localparam int          TW    = $clog2(TMAX + 1);
  localparam int          NB    = 6 + MAX_DATA;
  localparam int          IW    = 5;

  seq_state_t state_q;
  seq_phase_t phase_q;
  logic [IW-1:0] idx_q;
  logic          req_q, cs_q, ready_q;
  logic [7:0]    byte_q, stat_q;

  logic          t_load, t_exp;
  logic [TW-1:0] t_val;
  logic [7:0]    cur_byte, tb_byte;
  logic          cur_last, tb_last;
  logic          take, byte_done, frame_end;
  logic [8:0]    ie;

  assign take      = (state_q == ST_IDLE) && tx_valid;
  assign byte_done = (state_q == ST_SEND) && req_q && spi_ack;
  assign frame_end = byte_done && cur_last;

  can_seq_txbuf #(.MAX_DATA(MAX_DATA), .LEN_W(4), .SEL_W(IW)) u_txbuf (
    .clk(clk), .capture(take), .id(tx_id), .len(tx_len), .data(tx_data),
    .sel(idx_q), .byte_o(tb_byte), .last_o(tb_last)
  );

  can_seq_timer #(.W(TW), .RST_VAL(CS_GAP_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  always_comb begin
    ie = init_entry(idx_q, PRESC);
    case (phase_q)
      PH_INIT: begin cur_byte = ie[7:0];     cur_last = ie[8];   end
      PH_LOAD: begin cur_byte = tb_byte;     cur_last = tb_last; end
      PH_RTS:  begin cur_byte = OP_RTS_TXB0; cur_last = 1'b1;    end
      default: begin cur_byte = 8'h00;       cur_last = 1'b1;    end
    endcase
  end

  // One interval timer serves both the post-reset wait and the chip-select gap
  always_comb begin
    t_load = 1'b0;
    t_val  = TW'(CS_GAP_CYCLES);
    if (frame_end) begin
      t_load = 1'b1;
      if (phase_q == PH_INIT && idx_q == '0) t_val = TW'(RESET_WAIT_CYCLES);
    end else if (state_q == ST_RSTWAIT && t_exp) begin
      t_load = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_GAP;
      phase_q <= PH_INIT;
      idx_q   <= '0;
      req_q   <= 1'b0;
      cs_q    <= 1'b1;
      ready_q <= 1'b0;
      byte_q  <= 8'h00;
      stat_q  <= 8'h00;
    end else begin
      case (state_q)
        ST_GAP: begin
          if (t_exp) begin
            if (phase_q == PH_DONE) begin
              state_q <= ST_IDLE;
              ready_q <= 1'b1;
            end else begin
              state_q <= ST_SEND;
              cs_q    <= 1'b0;
            end
          end
        end
        ST_RSTWAIT: begin
          if (t_exp) state_q <= ST_GAP;
        end
        ST_IDLE: begin
          if (tx_valid) begin
            ready_q <= 1'b0;
            phase_q <= PH_LOAD;
            idx_q   <= '0;
            state_q <= ST_SEND;
            cs_q    <= 1'b0;
          end
        end
        default: begin
          if (!req_q) begin
            req_q  <= 1'b1;
            byte_q <= cur_byte;
          end else if (spi_ack) begin
            req_q <= 1'b0;
            if (phase_q == PH_INIT && idx_q == IW'(2)) stat_q <= spi_rx;
            if (cur_last) begin
              cs_q    <= 1'b1;
              state_q <= ST_GAP;
              idx_q   <= '0;
              case (phase_q)
                PH_INIT: begin
                  if (idx_q == '0) state_q <= ST_RSTWAIT;
                  if (idx_q == IW'(INIT_LEN - 1)) phase_q <= PH_DONE;
                  else idx_q <= idx_q + 1'b1;
                end
                PH_LOAD: phase_q <= PH_RTS;
                default: phase_q <= PH_DONE;
              endcase
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign tx_ready    = ready_q;
  assign spi_cs_n    = cs_q;
  assign spi_req     = req_q;
  assign spi_byte    = byte_q;
  assign status_byte = stat_q;

  if (NB > (1 << IW)) begin : g_bad_cfg
    initial $error("MAX_DATA too large for index width");
  end
endmodule

// File: rtl/can_spi_seq_chk.sv
module can_spi_seq_chk #(
  parameter int unsigned CS_GAP_CYCLES = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       spi_cs_n,
  input logic       spi_req,
  input logic [7:0] spi_byte,
  input logic       spi_ack
);
  localparam int CW = $clog2(CS_GAP_CYCLES + 2);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !spi_cs_n)             hi_cnt <= '0;
    else if (int'(hi_cnt) <= int'(CS_GAP_CYCLES)) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (spi_cs_n && !spi_req && !tx_ready));

  assert_req_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
    spi_req |-> !spi_cs_n);

  assert_cs_gap_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> (int'(hi_cnt) >= int'(CS_GAP_CYCLES)));

  assert_byte_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (spi_req && !spi_ack) |=> (spi_req && $stable(spi_byte)));

  assert_one_per_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (spi_req && spi_ack) |=> !spi_req);

  assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (spi_cs_n && !spi_req));

  assert_accept_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

bind can_spi_seq can_spi_seq_chk #(.CS_GAP_CYCLES(CS_GAP_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .spi_cs_n(spi_cs_n), .spi_req(spi_req), .spi_byte(spi_byte), .spi_ack(spi_ack)
);

// File: tb/tb_can_spi_seq.sv
module tb_can_spi_seq;
  localparam int unsigned RW  = 200;
  localparam int unsigned GAP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [31:0] tx_id = '0;
  logic [3:0]  tx_len = '0;
  logic [63:0] tx_data = '0;
  logic        spi_cs_n, spi_req, spi_ack;
  logic [7:0]  spi_byte, spi_rx, status_byte;

  int errors = 0, checks = 0;
  logic [7:0] cap_b [0:511];
  int         cap_f [0:511];
  int         n_cap = 0, fr = 0, cnt = 0;
  logic [7:0] exp_b [0:511];
  int         exp_f [0:511];
  string      exp_t [0:511];
  int         n_exp = 0, exp_fr = 0;
  int         hi_run = 0, gap0 = 0, min_gap = 1000000;
  logic       cs_prev = 1'b1;
  bit         done = 0;

  initial spi_ack = 1'b0;
  initial spi_rx  = 8'h00;

  always #4 clk = ~clk;

  can_spi_seq #(.RESET_WAIT_CYCLES(RW), .CS_GAP_CYCLES(GAP)) dut (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_id(tx_id), .tx_len(tx_len), .tx_data(tx_data),
    .spi_cs_n(spi_cs_n), .spi_req(spi_req), .spi_byte(spi_byte),
    .spi_ack(spi_ack), .spi_rx(spi_rx), .status_byte(status_byte)
  );

  // Shifter model: acknowledges three cycles after seeing a request
  always @(posedge clk) begin
    if (rst) begin
      spi_ack <= 1'b0; cnt <= 0;
    end else if (spi_ack) begin
      spi_ack <= 1'b0; cnt <= 0;
    end else if (spi_req) begin
      if (cnt == 2) begin
        spi_ack <= 1'b1;
        spi_rx  <= 8'(n_cap) ^ 8'h3C;
        cap_b[n_cap] <= spi_byte;
        cap_f[n_cap] <= fr;
        n_cap <= n_cap + 1;
      end else cnt <= cnt + 1;
    end
  end

  // Frame counting and chip-select high intervals
  always @(posedge clk) begin
    if (!rst) begin
      if (spi_cs_n && !cs_prev) begin fr <= fr + 1; hi_run <= 1; end
      else if (spi_cs_n) hi_run <= hi_run + 1;
      if (!spi_cs_n && cs_prev && fr > 0) begin
        if (fr == 1) gap0 <= hi_run;
        else if (hi_run < min_gap) min_gap <= hi_run;
      end
      cs_prev <= spi_cs_n;
    end
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input string tag);
    exp_b[n_exp] = b; exp_f[n_exp] = exp_fr; exp_t[n_exp] = tag; n_exp++;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic send(input logic [31:0] id, input logic [3:0] len, input logic [63:0] data);
    int n;
    n = (len > 8) ? 8 : int'(len);
    push(8'h40, "R8"); push(id[31:24], "R8"); push(id[23:16], "R8");
    push(id[15:8], "R8"); push(id[7:0], "R8"); push(8'(n), "R9");
    for (int k = 0; k < n; k++) push(data[8*k +: 8], "R8");
    exp_fr++;
    push(8'h81, "R10");
    exp_fr++;
    @(negedge clk);
    tx_id = id; tx_len = len; tx_data = data; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    check(tx_ready == 1'b0, "R7", "ready after accept", int'(tx_ready), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    // expected start-up script
    push(8'hC0, "R2"); exp_fr++;
    push(8'hB0, "R3"); push(8'hFF, "R3"); exp_fr++;
    push(8'h02, "R4"); push(8'h2F, "R4"); push(8'h80, "R4"); exp_fr++;
    push(8'h02, "R4"); push(8'h28, "R4"); push(8'h01, "R4"); push(8'h81, "R4");
    push(8'h0B, "R4"); push(8'hA7, "R4"); exp_fr++;
    push(8'h02, "R4"); push(8'h70, "R4"); push(8'h60, "R4"); exp_fr++;
    push(8'h02, "R4"); push(8'h2F, "R4"); push(8'h00, "R4"); exp_fr++;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(spi_cs_n && !spi_req && !tx_ready, "R1", "reset outputs",
          {spi_cs_n, spi_req, tx_ready}, 3'b100);
    rst = 1'b0;
    @(negedge clk);
    check(spi_cs_n && !spi_req && !tx_ready, "R1", "first cycle after reset",
          {spi_cs_n, spi_req, tx_ready}, 3'b100);
    repeat (40) @(negedge clk);
    check(tx_ready == 1'b0, "R11", "ready during start-up", int'(tx_ready), 0);

    // sweep all length codes; the first request is raised during start-up
    for (int i = 0; i < 16; i++) begin
      logic [63:0] d;
      for (int k = 0; k < 8; k++) d[8*k +: 8] = 8'(i * 16 + k + 1);
      send((32'h01020304 * (i + 1)) ^ 32'hA5000000, 4'(i), d);
    end
    while (!tx_ready) @(negedge clk);
    repeat (5) @(negedge clk);

    check(status_byte == (8'd2 ^ 8'h3C), "R3", "status byte", int'(status_byte), int'(8'd2 ^ 8'h3C));
    check(gap0 >= int'(RW), "R2", "post-reset wait", gap0, int'(RW));
    check(min_gap >= int'(GAP), "R5", "min cs gap", min_gap, int'(GAP));
    check(n_cap == n_exp, "R6", "byte count", n_cap, n_exp);
    check(fr == exp_fr, "R11", "frame count", fr, exp_fr);
    for (int j = 0; j < n_exp && j < n_cap; j++) begin
      check(cap_b[j] == exp_b[j], exp_t[j], $sformatf("byte %0d value", j), int'(cap_b[j]), int'(exp_b[j]));
      check(cap_f[j] == exp_f[j], exp_t[j], $sformatf("byte %0d frame", j), cap_f[j], exp_f[j]);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule